// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command front end of a byte-wide, EPROM-style nonvolatile memory, modelled behaviourally and synchronously. A host drives chip enable, output enable, write enable, an address and a data byte. A level input, `pgm_en`, stands in for the high-voltage supply. While `pgm_en` is low the part behaves as a read-only memory. While it is high, bytes written on the bus are decoded as commands. Those commands select identifier read, program, erase and the two verify modes, and they also capture the address and data that an operation needs.

A program or an erase runs as a pulse. The pulse begins on the write that completes its setup. It normally ends at the next matching verify write, so the spacing between host writes sets its length. An internal stop timer caps the pulse. When the timer reaches its limit first, the operation completes and the controller parks in a halted state. Only the matching verify command or the reset command leaves that state. A small register array stands in for the cells. Programming can only clear bits, and erasing sets every byte to all ones. The operation takes effect on the array when the pulse completes.

Top module: `flashcmd_ctrl`

## Requirements
- R1: After reset the mode is array read, every array byte reads 0xFF, and `pulse_busy`, `pulse_start`, `pulse_stop`, `timer_fired` and `rdata_valid` are low.
- R2: While `pgm_en` is low, all writes are ignored and the mode is forced to array read at the next edge. Any pulse in progress is aborted: `pulse_stop` strobes, and the array is left unchanged.
- R3: A read cycle is a clock edge with `ce_n`=0, `oe_n`=0 and `we_n`=1. One cycle later it gives `rdata_valid`=1 and the data selected by the mode. On every other cycle `rdata_valid` is 0 and `rdata` is 0.
- R4: A write is a clock edge with `ce_n`=0 and `we_n`=0. Outside a pulse or halt, data byte 0x00 or 0xFF selects array read and 0x90 selects identifier read. Any byte that is not a command code leaves the mode unchanged.
- R5: In identifier mode, a read returns `MFR_CODE` when address bit 0 is 0 and `DEV_CODE` when it is 1.
- R6: Writing 0x40 and then any byte captures that byte and its address, and starts a program pulse. `pulse_start` is high for one cycle and `pulse_busy` is high. A following 0xC0 write ends the pulse with a one-cycle `pulse_stop`. The target byte becomes old AND new, and later reads return the byte at the captured address.
- R7: Two consecutive 0x20 writes start an erase pulse. If the second write is any other byte, the controller returns to array read. A 0xA0 write ends the erase pulse and sets every byte to 0xFF. Later reads return the byte at the address of that 0xA0 write.
- R8: If no verify arrives, the stop timer ends the pulse after `PRG_LIMIT` cycles (program) or `ERS_LIMIT` cycles (erase) of `pulse_busy`. The operation is applied, `pulse_stop` strobes, and `timer_fired` goes high.
- R9: While halted after a timer stop, and during a pulse, writes other than the matching verify (0xC0 for program, 0xA0 for erase) or 0xFF are ignored. The matching verify leaves the halt and clears `timer_fired`.
- R10: A 0xFF write during a pulse aborts it with a `pulse_stop` strobe and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgm_en | input | 1 | Programming supply present; low locks out commands |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| wdata | input | 8 | Command or program data byte |
| rdata | output | 8 | Read data, registered |
| rdata_valid | output | 1 | High the cycle after a read cycle |
| pulse_start | output | 1 | One-cycle strobe when a program or erase pulse begins |
| pulse_stop | output | 1 | One-cycle strobe when a pulse ends for any reason |
| pulse_busy | output | 1 | A program or erase pulse is in progress |
| timer_fired | output | 1 | Halted after the stop timer ended a pulse |

## Verification
Every result is due exactly one cycle after the edge that caused it. This holds for read data, mode changes and the strobes, whether the cause is a write or a drop of `pgm_en`. A timer stop shows `pulse_busy` for exactly the limit count of cycles counted from that first cycle, and `timer_fired` with `pulse_stop` on the cycle after. The bench drives its inputs on the falling edge and samples on the next falling edge, so each check lands half a cycle after the rising edge that produced the value. Timer checks walk the pulse cycle by cycle and compare it against the limit. Array contents are tracked in a bench model: AND for program, all ones for erase.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_IDENT,
        ST_ERS_SETUP,
        ST_ERASING,
        ST_ERS_VERIFY,
        ST_PRG_SETUP,
        ST_PROGRAMMING,
        ST_PRG_VERIFY,
        ST_HALT_ERS,
        ST_HALT_PRG
    } mode_e;

    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_ERS     = 8'h20;
    localparam logic [7:0] CMD_ERS_VFY = 8'hA0;
    localparam logic [7:0] CMD_PRG     = 8'h40;
    localparam logic [7:0] CMD_PRG_VFY = 8'hC0;
    localparam logic [7:0] CMD_RESET   = 8'hFF;

    function automatic logic in_pulse(input mode_e m);
        return (m == ST_ERASING) || (m == ST_PROGRAMMING);
    endfunction

    function automatic logic in_halt(input mode_e m);
        return (m == ST_HALT_ERS) || (m == ST_HALT_PRG);
    endfunction

endpackage

// File: rtl/flashcmd_timer.sv
module flashcmd_timer #(
    parameter int PRG_LIMIT = 6,
    parameter int ERS_LIMIT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic erase_sel,
    output logic expire
);
    localparam int MAXL = (PRG_LIMIT > ERS_LIMIT) ? PRG_LIMIT : ERS_LIMIT;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] PRG_LAST = CW'(PRG_LIMIT - 1);
    localparam logic [CW-1:0] ERS_LAST = CW'(ERS_LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last   = erase_sel ? ERS_LAST : PRG_LAST;
        cnt_d  = run ? cnt_q + CW'(1) : '0;
        expire = run && (cnt_q == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/flashcmd_array.sv
module flashcmd_array #(
    parameter int         AW     = 4,
    parameter logic [7:0] ERASED = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_prog,
    input  logic          do_erase,
    input  logic [AW-1:0] prg_addr,
    input  logic [7:0]    prg_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (do_erase)
                mem_d[i] = ERASED;
            else if (do_prog && (prg_addr == AW'(i)))
                mem_d[i] = mem_q[i] & prg_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= {DEPTH{ERASED}};
        else        mem_q <= mem_d;
    end

    assign rd_byte = mem_q[rd_addr];

    assert_apply_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_prog && do_erase));

    assert_erase_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_erase |=> (rd_byte == ERASED));

endmodule

// File: rtl/flashcmd_fsm.sv
module flashcmd_fsm
    import flashcmd_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pgm_en,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          expire,
    output mode_e         mode,
    output logic [AW-1:0] lat_addr,
    output logic [7:0]    lat_data,
    output logic          do_prog,
    output logic          do_erase,
    output logic          pulse_start,
    output logic          pulse_stop
);
    typedef struct packed {
        mode_e         mode;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          pstart;
        logic          pstop;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pstart = 1'b0;
        st_d.pstop  = 1'b0;
        do_prog     = 1'b0;
        do_erase    = 1'b0;
        if (!pgm_en) begin
            st_d.mode  = ST_READ;
            st_d.pstop = in_pulse(st_q.mode);
        end else begin
            case (st_q.mode)
                ST_ERASING: begin
                    if (wr_stb && wr_data == CMD_ERS_VFY) begin
                        st_d.mode  = ST_ERS_VERIFY;
                        st_d.addr  = wr_addr;
                        st_d.pstop = 1'b1;
                        do_erase   = 1'b1;
                    end else if (wr_stb && wr_data == CMD_RESET) begin
                        st_d.mode  = ST_READ;
                        st_d.pstop = 1'b1;
                    end else if (expire) begin
                        st_d.mode  = ST_HALT_ERS;
                        st_d.pstop = 1'b1;
                        do_erase   = 1'b1;
                    end
                end
                ST_PROGRAMMING: begin
                    if (wr_stb && wr_data == CMD_PRG_VFY) begin
                        st_d.mode  = ST_PRG_VERIFY;
                        st_d.pstop = 1'b1;
                        do_prog    = 1'b1;
                    end else if (wr_stb && wr_data == CMD_RESET) begin
                        st_d.mode  = ST_READ;
                        st_d.pstop = 1'b1;
                    end else if (expire) begin
                        st_d.mode  = ST_HALT_PRG;
                        st_d.pstop = 1'b1;
                        do_prog    = 1'b1;
                    end
                end
                ST_HALT_ERS: begin
                    if (wr_stb && wr_data == CMD_ERS_VFY) begin
                        st_d.mode = ST_ERS_VERIFY;
                        st_d.addr = wr_addr;
                    end else if (wr_stb && wr_data == CMD_RESET) begin
                        st_d.mode = ST_READ;
                    end
                end
                ST_HALT_PRG: begin
                    if (wr_stb && wr_data == CMD_PRG_VFY)
                        st_d.mode = ST_PRG_VERIFY;
                    else if (wr_stb && wr_data == CMD_RESET)
                        st_d.mode = ST_READ;
                end
                ST_ERS_SETUP: begin
                    if (wr_stb) begin
                        if (wr_data == CMD_ERS) begin
                            st_d.mode   = ST_ERASING;
                            st_d.pstart = 1'b1;
                        end else begin
                            st_d.mode = ST_READ;
                        end
                    end
                end
                ST_PRG_SETUP: begin
                    if (wr_stb) begin
                        st_d.mode   = ST_PROGRAMMING;
                        st_d.addr   = wr_addr;
                        st_d.data   = wr_data;
                        st_d.pstart = 1'b1;
                    end
                end
                default: begin
                    if (wr_stb) begin
                        case (wr_data)
                            CMD_READ, CMD_RESET: st_d.mode = ST_READ;
                            CMD_IDENT:           st_d.mode = ST_IDENT;
                            CMD_ERS:             st_d.mode = ST_ERS_SETUP;
                            CMD_PRG:             st_d.mode = ST_PRG_SETUP;
                            CMD_ERS_VFY: begin
                                st_d.mode = ST_ERS_VERIFY;
                                st_d.addr = wr_addr;
                            end
                            CMD_PRG_VFY:         st_d.mode = ST_PRG_VERIFY;
                            default:             st_d.mode = st_q.mode;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: ST_READ, addr: '0, data: '0, pstart: 1'b0, pstop: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode        = st_q.mode;
    assign lat_addr    = st_q.addr;
    assign lat_data    = st_q.data;
    assign pulse_start = st_q.pstart;
    assign pulse_stop  = st_q.pstop;

    assert_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_en |=> (st_q.mode == ST_READ));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_halt(st_q.mode) && pgm_en && !wr_stb) |=> (st_q.mode == $past(st_q.mode)));

    assert_timer_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pulse(st_q.mode) && pgm_en && !wr_stb && expire) |=> in_halt(st_q.mode));

endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
    import flashcmd_pkg::*;
#(
    parameter int         AW        = 4,
    parameter int         PRG_LIMIT = 6,
    parameter int         ERS_LIMIT = 9,
    parameter logic [7:0] MFR_CODE  = 8'h89,
    parameter logic [7:0] DEV_CODE  = 8'hB4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pgm_en,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          rdata_valid,
    output logic          pulse_start,
    output logic          pulse_stop,
    output logic          pulse_busy,
    output logic          timer_fired
);
    typedef struct packed {
        logic [7:0] data;
        logic       valid;
    } rd_t;

    mode_e         mode;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data;
    logic          do_prog, do_erase, expire;
    logic          wr_stb, rd_cyc;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_byte;
    rd_t           rd_d, rd_q;

    assign wr_stb = !ce_n && !we_n;
    assign rd_cyc = !ce_n && !oe_n && we_n;

    flashcmd_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en),
        .wr_stb(wr_stb), .wr_addr(addr), .wr_data(wdata),
        .expire(expire), .mode(mode),
        .lat_addr(lat_addr), .lat_data(lat_data),
        .do_prog(do_prog), .do_erase(do_erase),
        .pulse_start(pulse_start), .pulse_stop(pulse_stop)
    );

    flashcmd_timer #(.PRG_LIMIT(PRG_LIMIT), .ERS_LIMIT(ERS_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .run(in_pulse(mode)), .erase_sel(mode == ST_ERASING),
        .expire(expire)
    );

    flashcmd_array #(.AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .do_prog(do_prog), .do_erase(do_erase),
        .prg_addr(lat_addr), .prg_data(lat_data),
        .rd_addr(arr_addr), .rd_byte(arr_byte)
    );

    always_comb begin
        arr_addr = ((mode == ST_ERS_VERIFY) || (mode == ST_PRG_VERIFY)) ? lat_addr : addr;
        rd_d     = '0;
        if (rd_cyc) begin
            rd_d.valid = 1'b1;
            if (mode == ST_IDENT) rd_d.data = addr[0] ? DEV_CODE : MFR_CODE;
            else                  rd_d.data = arr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata       = rd_q.data;
    assign rdata_valid = rd_q.valid;
    assign pulse_busy  = in_pulse(mode);
    assign timer_fired = in_halt(mode);

    assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cyc |=> (!rdata_valid && rdata == 8'h00));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_start && pulse_stop));

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |-> pulse_busy);

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_stop |-> !pulse_busy);

    assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_en && pulse_busy) |=> (pulse_stop && !timer_fired));

endmodule

// File: tb/flashcmd_ctrl_test.sv
`timescale 1ns/1ps
module flashcmd_ctrl_test;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int PL = 6;
    localparam int EL = 9;
    localparam logic [7:0] MFR = 8'h89;
    localparam logic [7:0] DEV = 8'hB4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pgm_en = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rdata_valid, pulse_start, pulse_stop, pulse_busy, timer_fired;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];
    logic [7:0] rv;

    always #2 clk = ~clk;

    flashcmd_ctrl #(.AW(AW), .PRG_LIMIT(PL), .ERS_LIMIT(EL),
                    .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid),
        .pulse_start(pulse_start), .pulse_stop(pulse_stop),
        .pulse_busy(pulse_busy), .timer_fired(timer_fired)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        chk("R3 read valid", {7'd0, rdata_valid}, 8'd1);
        d = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), rv);
            chk(tag, rv, model[a]);
        end
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        wr('0, 8'h40);
        wr(a, d);
        chk("R6 start strobe", {7'd0, pulse_start}, 8'd1);
        chk("R6 busy", {7'd0, pulse_busy}, 8'd1);
        wr('0, 8'hC0);
        chk("R6 stop strobe", {7'd0, pulse_stop}, 8'd1);
        chk("R6 busy cleared", {7'd0, pulse_busy}, 8'd0);
        model[a] = model[a] & d;
        rd(a ^ AW'(1), rv);
        chk("R6 program verify", rv, model[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {7'd0, pulse_busy}, 8'd0);
        chk("R1 fired", {7'd0, timer_fired}, 8'd0);
        chk("R1 strobes", {6'd0, pulse_start, pulse_stop}, 8'd0);
        chk("R1 valid", {7'd0, rdata_valid}, 8'd0);
        read_all("R1 erased array");

        // R3 standby and output disable
        ce_n = 1'b1; oe_n = 1'b0; @(negedge clk);
        chk("R3 standby valid", {7'd0, rdata_valid}, 8'd0);
        chk("R3 standby data", rdata, 8'd0);
        ce_n = 1'b0; oe_n = 1'b1; @(negedge clk);
        chk("R3 output disable", {7'd0, rdata_valid}, 8'd0);
        ce_n = 1'b1;

        // R2 writes ignored while locked
        wr(4'd1, 8'h90);
        rd(4'd1, rv); chk("R2 ident ignored", rv, 8'hFF);
        wr(4'd3, 8'h40); wr(4'd3, 8'h00);
        chk("R2 no pulse", {7'd0, pulse_busy}, 8'd0);
        rd(4'd3, rv); chk("R2 array intact", rv, 8'hFF);

        pgm_en = 1'b1;
        @(negedge clk);
        // R5 identifier sweep
        wr('0, 8'h90);
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), rv);
            chk("R5 identifier", rv, (a % 2 == 1) ? DEV : MFR);
        end
        // R4 unknown code ignored, reset returns to array
        wr('0, 8'h55);
        rd(4'd1, rv); chk("R4 unknown ignored", rv, DEV);
        wr('0, 8'hFF);
        rd(4'd1, rv); chk("R4 reset to array", rv, model[1]);
        wr('0, 8'h90); wr('0, 8'h00);
        rd(4'd0, rv); chk("R4 array read cmd", rv, model[0]);

        // R6 program sweep
        for (int a = 0; a < DEPTH; a++) prog(AW'(a), 8'((a * 53 + 7) | 8'h10));
        wr('0, 8'h00);
        read_all("R6 array after program");

        // R8 program stop timer
        wr('0, 8'h40); wr(4'd2, 8'h0F);
        for (int k = 1; k <= PL; k++) begin
            if (k > 1) @(negedge clk);
            chk("R8 program busy window", {6'd0, pulse_busy, timer_fired}, 8'd2);
        end
        @(negedge clk);
        chk("R8 program timer end", {5'd0, pulse_busy, timer_fired, pulse_stop}, 8'd3);
        model[2] = model[2] & 8'h0F;
        // R9 halt holds against other writes
        wr('0, 8'h90);
        chk("R9 halt after ident", {7'd0, timer_fired}, 8'd1);
        wr('0, 8'hA0);
        chk("R9 halt after wrong verify", {7'd0, timer_fired}, 8'd1);
        wr('0, 8'hC0);
        chk("R9 verify leaves halt", {7'd0, timer_fired}, 8'd0);
        rd(4'd7, rv); chk("R8 program applied", rv, model[2]);

        // R9 ignored write during a pulse, R10 reset abort
        wr('0, 8'h40); wr(4'd5, 8'h00);
        wr('0, 8'h90);
        chk("R9 pulse ignores ident", {7'd0, pulse_busy}, 8'd1);
        wr('0, 8'hFF);
        chk("R10 abort strobe", {6'd0, pulse_busy, pulse_stop}, 8'd1);
        rd(4'd5, rv); chk("R10 array unchanged", rv, model[5]);

        // R2 pgm_en drop aborts pulse
        wr('0, 8'h40); wr(4'd6, 8'h00);
        pgm_en = 1'b0; @(negedge clk);
        chk("R2 drop aborts", {6'd0, pulse_busy, pulse_stop}, 8'd1);
        pgm_en = 1'b1;
        rd(4'd6, rv); chk("R2 abort no change", rv, model[6]);
        // R2 pgm_en drop leaves identifier mode
        wr('0, 8'h90);
        pgm_en = 1'b0; @(negedge clk); pgm_en = 1'b1;
        rd(4'd1, rv); chk("R2 drop to array", rv, model[1]);

        // R7 erase cancel, then erase with verify
        wr('0, 8'h20); wr('0, 8'h55);
        chk("R7 cancel no pulse", {7'd0, pulse_busy}, 8'd0);
        rd(4'd0, rv); chk("R7 cancel array read", rv, model[0]);
        wr('0, 8'h20); wr('0, 8'h20);
        chk("R7 erase start", {6'd0, pulse_busy, pulse_start}, 8'd3);
        wr(4'd9, 8'hA0);
        chk("R7 erase stop", {6'd0, pulse_busy, pulse_stop}, 8'd1);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        rd(4'd3, rv); chk("R7 erase verify", rv, 8'hFF);
        wr('0, 8'h00);
        read_all("R7 array after erase");

        // R8 erase stop timer
        prog(4'd1, 8'h12);
        wr('0, 8'h20); wr('0, 8'h20);
        for (int k = 1; k <= EL; k++) begin
            if (k > 1) @(negedge clk);
            chk("R8 erase busy window", {6'd0, pulse_busy, timer_fired}, 8'd2);
        end
        @(negedge clk);
        chk("R8 erase timer end", {5'd0, pulse_busy, timer_fired, pulse_stop}, 8'd3);
        model[1] = 8'hFF;
        wr('0, 8'hFF);
        chk("R9 reset leaves halt", {7'd0, timer_fired}, 8'd0);
        read_all("R8 erase applied");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule